// File: doc/BRIEF.md
# Bridge Protection and Power Supervisor

This block decides, cycle by cycle, whether each of two motor bridges may conduct. It also decides whether the internal logic is held in reset and whether the shared active-low fault line is pulled low. It takes five synchronous inputs: a run request (low means sleep), an undervoltage flag, an overtemperature flag whose hysteresis is applied upstream, and one raw overcurrent flag per bridge.

An overcurrent flag must stay high for a programmable number of consecutive cycles before its bridge is shut off. The shut-off bridge then stays off for a fixed retry window. When the window ends, the bridge is enabled again and the fault line is released. If the overcurrent persists, the shut-off and retry repeat. The other bridge keeps running throughout.

Sleep and undervoltage both reset the internal state, including all timers. After either one ends, a wake-up delay holds both bridges off. Overtemperature stops both bridges only while its flag is high. All three delays are counted in clock cycles and set by parameters.

Top module: `bridge_guard`

## Requirements
- R1: While `rst_n` is low at a rising edge, the edge leaves `bridgeEn` = 0, `logicRst` = 1 and `faultN` = 1.
- R2: A rising edge that samples `runReq` low leaves `bridgeEn` = 0, `logicRst` = 1 and `faultN` = 1, whatever the levels of `uvFlag`, `otFlag` and `ocRaw`.
- R3: After `runReq` goes high with `uvFlag` low, `logicRst` falls at the first rising edge and both enables rise at rising edge number `WAKE_CYC`.
- R4: An edge that samples `uvFlag` high while `runReq` is high gives `bridgeEn` = 0, `logicRst` = 1 and `faultN` = 0. Once the flag clears, the wake-up delay of R3 applies again.
- R5: An edge that samples `otFlag` high while the block is running gives `bridgeEn` = 0 and `faultN` = 0. The first edge after the flag clears restores both enables and `faultN` = 1, with no wake-up delay.
- R6: Bridge i (bit i of `ocRaw` and `bridgeEn`) is shut off, and `faultN` goes low, at the `DEGLITCH_CYC`-th consecutive rising edge that samples `ocRaw[i]` high. A shorter high pulse has no effect.
- R7: A shut-off bridge stays disabled for exactly `RETRY_CYC` cycles. It is then re-enabled and `faultN` is released on the same edge, provided no other fault is active.
- R8: If `ocRaw[i]` stays high, the bridge cycles between `RETRY_CYC` cycles off and `DEGLITCH_CYC` cycles on.
- R9: An overcurrent shut-off of one bridge does not change the enable of the other bridge.
- R10: Sleep and undervoltage clear the deglitch and retry timers. A bridge that was shut off before sleep comes back after the wake-up delay, and deglitch counting starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| runReq | input | 1 | High to run, low to sleep |
| uvFlag | input | 1 | Supply undervoltage, active high |
| otFlag | input | 1 | Die overtemperature, active high |
| ocRaw | input | 2 | Unfiltered overcurrent flag per bridge |
| bridgeEn | output | 2 | Enable for each bridge |
| logicRst | output | 1 | Synchronous reset for the internal logic |
| faultN | output | 1 | Fault indication, low = asserted (drives an open-drain pad) |

## Verification
Every output is a register fed by the current inputs and the next-state logic, so a level change on run, undervoltage or overtemperature shows up after one edge. An overcurrent shut-off lands on edge `DEGLITCH_CYC` of the high flag. The retry release comes `RETRY_CYC` edges later, and wake-up enables come on edge `WAKE_CYC` after release. The bench drives each stimulus on a falling edge and queues each expected value tagged with the exact edge count at which it is due. The monitor compares on the falling edge after that edge. It also checks the cycle just before each transition, so a result that arrives one cycle early or late is caught.

// File: rtl/guard_pkg.sv
package guard_pkg;
  localparam int BRIDGES = 2;

  // control -> timers
  typedef struct packed {
    logic               holdOff;   // clear every timer this cycle
    logic [BRIDGES-1:0] tripped;   // bridge is in its retry window
  } ctlStrobe_t;

  // timers -> control
  typedef struct packed {
    logic               wakeReady; // wake-up delay complete after this edge
    logic [BRIDGES-1:0] dgHit;     // overcurrent survived the deglitch window
    logic [BRIDGES-1:0] rtEnd;     // retry window ends at this edge
  } dpStrobe_t;
endpackage

// File: rtl/guard_timers.sv
module guard_timers
  import guard_pkg::*;
#(
  parameter int DEGLITCH_CYC = 32,
  parameter int RETRY_CYC    = 40000,
  parameter int WAKE_CYC     = 20000
) (
  input  logic               clk,
  input  ctlStrobe_t         ctl,
  input  logic [BRIDGES-1:0] ocRaw,
  output dpStrobe_t          st
);
  localparam int SPAN = (DEGLITCH_CYC > RETRY_CYC) ? DEGLITCH_CYC : RETRY_CYC;
  localparam int CW   = $clog2(SPAN + 1);
  localparam int WW   = $clog2(WAKE_CYC + 1);

  logic [WW-1:0] wakeCnt;

  always_ff @(posedge clk) begin
    if (ctl.holdOff)                  wakeCnt <= '0;
    else if (wakeCnt != WW'(WAKE_CYC)) wakeCnt <= wakeCnt + WW'(1);
  end

  assign st.wakeReady = !ctl.holdOff && (wakeCnt >= WW'(WAKE_CYC - 1));

  for (genvar i = 0; i < BRIDGES; i++) begin : g_br
    logic [CW-1:0] cnt;
    logic          hit;
    logic          fin;

    assign hit = !ctl.tripped[i] && ocRaw[i] && (cnt == CW'(DEGLITCH_CYC - 1));
    assign fin =  ctl.tripped[i] && (cnt == CW'(RETRY_CYC - 1));
    assign st.dgHit[i] = hit && !ctl.holdOff;
    assign st.rtEnd[i] = fin;

    always_ff @(posedge clk) begin
      if (ctl.holdOff)         cnt <= '0;
      else if (ctl.tripped[i]) cnt <= fin ? '0 : cnt + CW'(1);
      else if (ocRaw[i])       cnt <= hit ? '0 : cnt + CW'(1);
      else                     cnt <= '0;
    end
  end
endmodule

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import guard_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               runReq,
  input  logic               uvFlag,
  input  logic               otFlag,
  input  dpStrobe_t          st,
  output ctlStrobe_t         ctl,
  output logic [BRIDGES-1:0] bridgeEn,
  output logic               logicRst,
  output logic               faultN
);
  logic               holdOff;
  logic [BRIDGES-1:0] tripQ;
  logic [BRIDGES-1:0] tripNext;

  // sleep masks undervoltage; power-on reset behaves like sleep
  assign holdOff     = !rst_n || !runReq || uvFlag;
  assign ctl.holdOff = holdOff;
  assign ctl.tripped = tripQ;

  always_comb begin
    for (int i = 0; i < BRIDGES; i++) begin
      if (holdOff)       tripNext[i] = 1'b0;
      else if (tripQ[i]) tripNext[i] = !st.rtEnd[i];
      else               tripNext[i] = st.dgHit[i];
    end
  end

  always_ff @(posedge clk) tripQ <= tripNext;

  always_ff @(posedge clk) begin
    if (!rst_n || !runReq) begin
      bridgeEn <= '0;
      logicRst <= 1'b1;
      faultN   <= 1'b1;
    end else if (uvFlag) begin
      bridgeEn <= '0;
      logicRst <= 1'b1;
      faultN   <= 1'b0;
    end else begin
      bridgeEn <= {BRIDGES{st.wakeReady && !otFlag}} & ~tripNext;
      logicRst <= 1'b0;
      faultN   <= !(otFlag || (|tripNext));
    end
  end
endmodule

// File: rtl/bridge_guard.sv
module bridge_guard
  import guard_pkg::*;
#(
  parameter int DEGLITCH_CYC = 32,
  parameter int RETRY_CYC    = 40000,
  parameter int WAKE_CYC     = 20000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               runReq,
  input  logic               uvFlag,
  input  logic               otFlag,
  input  logic [BRIDGES-1:0] ocRaw,
  output logic [BRIDGES-1:0] bridgeEn,
  output logic               logicRst,
  output logic               faultN
);
  ctlStrobe_t ctl;
  dpStrobe_t  st;

  guard_timers #(
    .DEGLITCH_CYC(DEGLITCH_CYC),
    .RETRY_CYC   (RETRY_CYC),
    .WAKE_CYC    (WAKE_CYC)
  ) u_timers (
    .clk  (clk),
    .ctl  (ctl),
    .ocRaw(ocRaw),
    .st   (st)
  );

  guard_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .runReq  (runReq),
    .uvFlag  (uvFlag),
    .otFlag  (otFlag),
    .st      (st),
    .ctl     (ctl),
    .bridgeEn(bridgeEn),
    .logicRst(logicRst),
    .faultN  (faultN)
  );
endmodule

// File: rtl/guard_checker.sv
module guard_checker
  import guard_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               runReq,
  input logic               uvFlag,
  input logic               otFlag,
  input logic [BRIDGES-1:0] bridgeEn,
  input logic               logicRst,
  input logic               faultN
);
  assert_sleep_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !runReq |=> (bridgeEn == '0 && logicRst && faultN));

  assert_uv_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (runReq && uvFlag) |=> (bridgeEn == '0 && logicRst && !faultN));

  assert_ot_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (runReq && !uvFlag && otFlag) |=> (bridgeEn == '0 && !faultN));

  for (genvar i = 0; i < BRIDGES; i++) begin : g_chk
    assert_wake_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bridgeEn[i]) |-> $past(runReq && !uvFlag && !otFlag));
  end
endmodule

bind bridge_guard guard_checker u_guard_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .runReq  (runReq),
  .uvFlag  (uvFlag),
  .otFlag  (otFlag),
  .bridgeEn(bridgeEn),
  .logicRst(logicRst),
  .faultN  (faultN)
);

// File: tb/tb_bridge_guard.sv
module tb_bridge_guard;
  localparam int CLK_PERIOD = 10;
  localparam int DG = 4;
  localparam int RT = 12;
  localparam int WK = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       runReq = 1'b0;
  logic       uvFlag = 1'b0;
  logic       otFlag = 1'b0;
  logic [1:0] ocRaw = 2'b00;
  logic [1:0] bridgeEn;
  logic       logicRst;
  logic       faultN;

  int cycle = 0;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    int         cyc;
    logic [1:0] en;
    logic       rst;
    logic       fn;
    string      tag;
  } item_t;

  item_t expQ[$];

  bridge_guard #(.DEGLITCH_CYC(DG), .RETRY_CYC(RT), .WAKE_CYC(WK)) dut (
    .clk(clk), .rst_n(rst_n), .runReq(runReq), .uvFlag(uvFlag), .otFlag(otFlag),
    .ocRaw(ocRaw), .bridgeEn(bridgeEn), .logicRst(logicRst), .faultN(faultN)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  task automatic expectAt(int dly, logic [1:0] en, logic r, logic f, string tag);
    item_t it;
    it.cyc = cycle + dly; it.en = en; it.rst = r; it.fn = f; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // monitor: compares queued expectations on the falling edge
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0 && expQ[0].cyc <= cycle) begin
        item_t it;
        it = expQ.pop_front();
        checks++;
        if (it.cyc < cycle) begin
          failures++;
          $display("FAIL %s: check for cycle %0d missed at cycle %0d", it.tag, it.cyc, cycle);
        end else if (bridgeEn !== it.en || logicRst !== it.rst || faultN !== it.fn) begin
          failures++;
          $display("FAIL %s cycle %0d: en=%b rst=%b fault_n=%b expected en=%b rst=%b fault_n=%b",
                   it.tag, cycle, bridgeEn, logicRst, faultN, it.en, it.rst, it.fn);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cycle);
      summary();
      $finish;
    end
  end

  initial begin
    step(1);
    // R1: reset state
    expectAt(1, 2'b00, 1'b1, 1'b1, "R1");
    step(3);
    // R3: wake-up after release
    rst_n = 1'b1; runReq = 1'b1;
    expectAt(1,      2'b00, 1'b0, 1'b1, "R3");
    expectAt(WK - 1, 2'b00, 1'b0, 1'b1, "R3");
    expectAt(WK,     2'b11, 1'b0, 1'b1, "R3");
    step(WK + 2);

    // R6: pulse one edge short of the deglitch window is ignored
    ocRaw[0] = 1'b1;
    expectAt(DG - 1, 2'b11, 1'b0, 1'b1, "R6");
    expectAt(DG + 1, 2'b11, 1'b0, 1'b1, "R6");
    step(DG - 1);
    ocRaw[0] = 1'b0;
    step(4);

    // R6, R7, R9: bridge 1 trips, bridge 0 keeps running, release after RT
    ocRaw[1] = 1'b1;
    expectAt(DG - 1,      2'b11, 1'b0, 1'b1, "R6");
    expectAt(DG,          2'b01, 1'b0, 1'b0, "R6 R9");
    expectAt(DG + RT - 1, 2'b01, 1'b0, 1'b0, "R7 R9");
    expectAt(DG + RT,     2'b11, 1'b0, 1'b1, "R7");
    step(DG);
    ocRaw[1] = 1'b0;
    step(RT + 2);

    // R8: persistent overcurrent on bridge 0 repeats trip and retry
    ocRaw[0] = 1'b1;
    expectAt(DG,              2'b10, 1'b0, 1'b0, "R8");
    expectAt(DG + RT,         2'b11, 1'b0, 1'b1, "R8");
    expectAt(2*DG + RT - 1,   2'b11, 1'b0, 1'b1, "R8");
    expectAt(2*DG + RT,       2'b10, 1'b0, 1'b0, "R8");
    step(2*DG + RT + 1);
    ocRaw[0] = 1'b0;

    // R2: sleep while tripped, other inputs ignored
    runReq = 1'b0; uvFlag = 1'b1; otFlag = 1'b1; ocRaw = 2'b11;
    expectAt(1, 2'b00, 1'b1, 1'b1, "R2");
    expectAt(3, 2'b00, 1'b1, 1'b1, "R2");
    step(3);
    // R10: tripped bridge returns after wake delay
    runReq = 1'b1; uvFlag = 1'b0; otFlag = 1'b0; ocRaw = 2'b00;
    expectAt(WK - 1, 2'b00, 1'b0, 1'b1, "R10");
    expectAt(WK,     2'b11, 1'b0, 1'b1, "R10");
    step(WK + 2);

    // R10: deglitch count restarts across sleep
    ocRaw[1] = 1'b1;
    step(DG - 1);
    runReq = 1'b0; ocRaw[1] = 1'b0;
    step(2);
    runReq = 1'b1; ocRaw[1] = 1'b1;
    expectAt(DG, 2'b00, 1'b0, 1'b1, "R10");
    expectAt(WK, 2'b11, 1'b0, 1'b1, "R10");
    step(DG - 1);
    ocRaw[1] = 1'b0;
    step(WK + 2);

    // R5: overtemperature, no wake delay on recovery
    otFlag = 1'b1;
    expectAt(1, 2'b00, 1'b0, 1'b0, "R5");
    step(3);
    otFlag = 1'b0;
    expectAt(1, 2'b11, 1'b0, 1'b1, "R5");
    step(3);

    // R4: undervoltage, then wake delay again
    uvFlag = 1'b1;
    expectAt(1, 2'b00, 1'b1, 1'b0, "R4");
    step(3);
    uvFlag = 1'b0;
    expectAt(1,      2'b00, 1'b0, 1'b1, "R4");
    expectAt(WK - 1, 2'b00, 1'b0, 1'b1, "R4");
    expectAt(WK,     2'b11, 1'b0, 1'b1, "R4");
    step(WK + 3);

    while (expQ.size() > 0) step(1);
    finished = 1;
    summary();
    $finish;
  end
endmodule